// File: doc/BRIEF.md
# Strided Peripheral Byte Mover

This block is one DMA channel that carries bytes between memory and a set of byte-wide peripherals, one byte at a time. Software fills a small register set: the direction, which peripheral is used, a chunk length, a stride, a byte count and a start address. It then writes the go bit. In memory the channel walks either one contiguous buffer or a chain of equal chunks. Each chunk starts a fixed stride after the start of the one before it. The count and address registers are live: they show how far the transfer has gone. When the last byte has moved, the channel sends a single-cycle interrupt pulse.

The channel is a state machine that handles one byte per pass. The states are `ST_IDLE`, `ST_LAUNCH`, `ST_MEM_RD`, `ST_PER_TX`, `ST_PER_RX`, `ST_MEM_WR` and `ST_ADVANCE`. The transitions are:

- IDLE→LAUNCH on a go write.
- LAUNCH→MEM_RD or LAUNCH→PER_RX while the global enable is set. The direction picks which one.
- MEM_RD→PER_TX on a memory acknowledge.
- PER_TX→ADVANCE on peripheral ready.
- PER_RX→MEM_WR on peripheral valid.
- MEM_WR→ADVANCE on a memory acknowledge.
- ADVANCE→LAUNCH while bytes remain.
- ADVANCE→IDLE after the last byte.
- Any state→IDLE on a halt write.

Register word indices are: 0 global enable (bit 0), 1 command (write bit 0 = go, bit 1 = halt; read bit 0 = busy), 2 transfer control, 3 chunk, 4 stride, 5 count, 6 address. Writes to indices 2 to 6 are ignored while the channel is busy.

Top module: `pdma_channel`

## Requirements
- R1: After reset, busy reads 0, count reads 0xFFFFF, address reads 0, irq is 0, and no memory request, peripheral valid or peripheral ready is driven.
- R2: Writing the command word with bit 0 set and bit 1 clear starts a transfer. Command bit 0 then reads 1 until the transfer ends.
- R3: Writing the command word with bit 1 set ends the transfer in the next cycle. Busy drops, no interrupt is raised, no further request is made, and the count keeps its current value. Halt wins over go when both bits are written together.
- R4: Transfer-control bit 0 selects the direction: 1 = memory to peripheral, 0 = peripheral to memory. Bits 3:1 are driven on `per_sel` throughout the transfer.
- R5: With a chunk length of 0, the bytes use consecutive addresses and the stride has no effect.
- R6: With a nonzero chunk length C, each chunk covers C consecutive addresses. Each chunk starts stride bytes after the start of the one before it.
- R7: The 20-bit count holds remaining bytes minus one. It decrements by one for each byte moved and reads 0xFFFFF when the transfer is complete.
- R8: The 24-bit address register shows the address of the next byte. After completion it holds the address the walk would visit next.
- R9: `irq` pulses for exactly one cycle when the transfer completes. It is high in the first cycle in which busy reads 0.
- R10: While global enable bit 0 is 0, no new byte begins and the transfer waits. It resumes when the bit is set again.
- R11: The peripheral valid/ready handshake loses and duplicates no byte. `per_tx_data` stays stable while valid is high and ready is low.
- R12: A memory request holds its address, write flag and write data steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read byte, valid with acknowledge |
| per_sel | output | 3 | Peripheral select |
| per_tx_valid | output | 1 | Byte offered to peripheral |
| per_tx_data | output | 8 | Byte to peripheral |
| per_tx_ready | input | 1 | Peripheral accepts byte |
| per_rx_valid | input | 1 | Peripheral offers byte |
| per_rx_data | input | 8 | Byte from peripheral |
| per_rx_ready | output | 1 | Channel accepts byte |
| irq | output | 1 | Completion pulse |

## Verification
The assertions check several rules on every cycle:

- The handshake-hold rules for the peripheral and memory ports.
- The single-cycle width of the interrupt, and that it coincides with idle and an all-ones count.
- That a halt leaves the channel idle in the next cycle.
- That no byte begins while the global enable is clear.

The chunk and stride address walk, the byte order and content at the ports, and the final count and address readback can only be shown by the bench's scenarios. The same holds for the mid-transfer halt and for halt winning over go. The bench compares against an address model that it computes itself.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_MEM_RD,
        ST_PER_TX,
        ST_PER_RX,
        ST_MEM_WR,
        ST_ADVANCE
    } pdma_state_e;

    localparam int unsigned RIDX_W = 3;

    localparam logic [RIDX_W-1:0] RA_GLOBAL = 3'd0;
    localparam logic [RIDX_W-1:0] RA_CMD    = 3'd1;
    localparam logic [RIDX_W-1:0] RA_XCTL   = 3'd2;
    localparam logic [RIDX_W-1:0] RA_CHUNK  = 3'd3;
    localparam logic [RIDX_W-1:0] RA_STRIDE = 3'd4;
    localparam logic [RIDX_W-1:0] RA_COUNT  = 3'd5;
    localparam logic [RIDX_W-1:0] RA_ADDR   = 3'd6;

    localparam int unsigned CMD_GO_BIT   = 0;
    localparam int unsigned CMD_HALT_BIT = 1;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned REG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [RIDX_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                busy,
    input  logic [CNT_W-1:0]    live_count,
    input  logic [ADDR_W-1:0]   live_addr,
    output logic                gen_en,
    output logic                dir_m2p,
    output logic [SEL_W-1:0]    per_sel,
    output logic [LEN_W-1:0]    chunk,
    output logic [LEN_W-1:0]    stride,
    output logic                go,
    output logic                halt,
    output logic                load_count,
    output logic                load_addr
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned XCTL_W = SEL_W + 1;

    logic cfg_wr;
    logic cmd_wr;

    assign cfg_wr = reg_we && !busy;
    assign cmd_wr = reg_we && (reg_addr == RA_CMD);

    assign go         = cmd_wr && reg_wdata[CMD_GO_BIT] && !reg_wdata[CMD_HALT_BIT];
    assign halt       = cmd_wr && reg_wdata[CMD_HALT_BIT];
    assign load_count = cfg_wr && (reg_addr == RA_COUNT);
    assign load_addr  = cfg_wr && (reg_addr == RA_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en  <= 1'b0;
            dir_m2p <= 1'b0;
            per_sel <= '0;
            chunk   <= '0;
            stride  <= '0;
        end else begin
            if (reg_we && (reg_addr == RA_GLOBAL)) begin
                gen_en <= reg_wdata[0];
            end
            if (cfg_wr && (reg_addr == RA_XCTL)) begin
                {per_sel, dir_m2p} <= reg_wdata[XCTL_W-1:0];
            end
            if (cfg_wr && (reg_addr == RA_CHUNK)) begin
                chunk <= reg_wdata[LEN_W-1:0];
            end
            if (cfg_wr && (reg_addr == RA_STRIDE)) begin
                stride <= reg_wdata[LEN_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_GLOBAL: reg_rdata[0] = gen_en;
            RA_CMD:    reg_rdata[0] = busy;
            RA_XCTL:   reg_rdata[XCTL_W-1:0] = {per_sel, dir_m2p};
            RA_CHUNK:  reg_rdata[LEN_W-1:0] = chunk;
            RA_STRIDE: reg_rdata[LEN_W-1:0] = stride;
            RA_COUNT:  reg_rdata[CNT_W-1:0] = live_count;
            RA_ADDR:   reg_rdata[ADDR_W-1:0] = live_addr;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pdma_walker.sv
module pdma_walker #(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_count,
    input  logic [CNT_W-1:0]  count_val,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              begin_xfer,
    input  logic              step,
    input  logic [LEN_W-1:0]  chunk,
    input  logic [LEN_W-1:0]  stride,
    output logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned PAD_W = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] line_base;
    logic [LEN_W-1:0]  pos;
    logic              chunked;
    logic              chunk_end;
    logic [ADDR_W-1:0] line_next;

    assign chunked   = (chunk != '0);
    assign chunk_end = chunked && (pos == (chunk - 1'b1));
    assign line_next = line_base + {{PAD_W{1'b0}}, stride};
    assign last      = (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '1;
            addr      <= '0;
            line_base <= '0;
            pos       <= '0;
        end else begin
            if (load_count) begin
                count <= count_val;
            end
            if (load_addr) begin
                addr <= addr_val;
            end
            if (begin_xfer) begin
                line_base <= addr;
                pos       <= '0;
            end
            if (step) begin
                count <= count - 1'b1;
                if (chunk_end) begin
                    addr      <= line_next;
                    line_base <= line_next;
                    pos       <= '0;
                end else begin
                    addr <= addr + 1'b1;
                    if (chunked) begin
                        pos <= pos + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              halt,
    input  logic              gen_en,
    input  logic              dir_m2p,
    input  logic              last,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_ready,
    output logic              begin_xfer,
    output logic              step,
    output logic              busy,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 100ps;

    pdma_state_e       state_q;
    pdma_state_e       state_d;
    logic [DATA_W-1:0] data_q;
    logic              irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (go) state_d = ST_LAUNCH;
                ST_LAUNCH:  if (gen_en) state_d = dir_m2p ? ST_MEM_RD : ST_PER_RX;
                ST_MEM_RD:  if (mem_ack) state_d = ST_PER_TX;
                ST_PER_TX:  if (tx_ready) state_d = ST_ADVANCE;
                ST_PER_RX:  if (rx_valid) state_d = ST_MEM_WR;
                ST_MEM_WR:  if (mem_ack) state_d = ST_ADVANCE;
                ST_ADVANCE: state_d = last ? ST_IDLE : ST_LAUNCH;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        tx_valid = 1'b0;
        rx_ready = 1'b0;
        step     = 1'b0;
        unique case (state_q)
            ST_MEM_RD:  mem_req = 1'b1;
            ST_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_PER_TX:  tx_valid = 1'b1;
            ST_PER_RX:  rx_ready = 1'b1;
            ST_ADVANCE: step = !halt;
            default:    step = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if ((state_q == ST_MEM_RD) && mem_ack) begin
                data_q <= mem_rdata;
            end else if ((state_q == ST_PER_RX) && rx_valid) begin
                data_q <= rx_data;
            end
            irq_q <= (state_q == ST_ADVANCE) && last && !halt;
        end
    end

    assign begin_xfer = (state_q == ST_IDLE) && go;
    assign busy       = (state_q != ST_IDLE);
    assign irq        = irq_q;
    assign mem_wdata  = data_q;
    assign tx_data    = data_q;
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [SEL_W-1:0]  per_sel,
    output logic              per_tx_valid,
    output logic [DATA_W-1:0] per_tx_data,
    input  logic              per_tx_ready,
    input  logic              per_rx_valid,
    input  logic [DATA_W-1:0] per_rx_data,
    output logic              per_rx_ready,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic              busy;
    logic              gen_en;
    logic              dir_m2p;
    logic [LEN_W-1:0]  chunk;
    logic [LEN_W-1:0]  stride;
    logic              go;
    logic              halt_pulse;
    logic              load_count;
    logic              load_addr;
    logic              begin_xfer;
    logic              step;
    logic              last;
    logic [CNT_W-1:0]  live_count;
    logic [ADDR_W-1:0] live_addr;

    pdma_regs #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .SEL_W (SEL_W),
        .REG_W (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .live_count(live_count),
        .live_addr (live_addr),
        .gen_en    (gen_en),
        .dir_m2p   (dir_m2p),
        .per_sel   (per_sel),
        .chunk     (chunk),
        .stride    (stride),
        .go        (go),
        .halt      (halt_pulse),
        .load_count(load_count),
        .load_addr (load_addr)
    );

    pdma_walker #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_count(load_count),
        .count_val (reg_wdata[CNT_W-1:0]),
        .load_addr (load_addr),
        .addr_val  (reg_wdata[ADDR_W-1:0]),
        .begin_xfer(begin_xfer),
        .step      (step),
        .chunk     (chunk),
        .stride    (stride),
        .count     (live_count),
        .addr      (live_addr),
        .last      (last)
    );

    pdma_engine #(
        .DATA_W(DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .halt      (halt_pulse),
        .gen_en    (gen_en),
        .dir_m2p   (dir_m2p),
        .last      (last),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_ready  (per_tx_ready),
        .rx_valid  (per_rx_valid),
        .rx_data   (per_rx_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .tx_valid  (per_tx_valid),
        .tx_data   (per_tx_data),
        .rx_ready  (per_rx_ready),
        .begin_xfer(begin_xfer),
        .step      (step),
        .busy      (busy),
        .irq       (irq)
    );

    assign mem_addr = live_addr;
endmodule

// File: rtl/pdma_checker.sv
module pdma_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 20,
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              gen_en,
    input logic              halt,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              rx_ready
);
    timeunit 1ns;
    timeprecision 100ps;

    AST_HALT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !busy); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid && !rx_ready)); // R3

    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '1)); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9

    AST_IRQ_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R9

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req && !mem_we) || $rose(rx_ready)) |-> $past(gen_en)); // R10

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !halt) |=> (tx_valid && $stable(tx_data))); // R11

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !halt) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
endmodule

bind pdma_channel pdma_checker #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_pdma_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .gen_en   (gen_en),
    .halt     (halt_pulse),
    .irq      (irq),
    .count    (live_count),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .tx_valid (per_tx_valid),
    .tx_ready (per_tx_ready),
    .tx_data  (per_tx_data),
    .rx_ready (per_rx_ready)
);

// File: tb/pdma_channel_bench.sv
module pdma_channel_bench;
    import pdma_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic        dir;
        logic [2:0]  sel;
        logic [11:0] chunk;
        logic [11:0] stride;
        logic [19:0] cnt;
        logic [23:0] addr;
        logic [23:0] fin;
        logic [3:0]  lat;
        logic [7:0]  rdy;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd2, 12'd0, 12'd7, 20'd4, 24'h000010, 24'h000015, 4'd0, 8'hFF},
        '{1'b1, 3'd6, 12'd2, 12'd5, 20'd5, 24'h000020, 24'h00002F, 4'd2, 8'hB2},
        '{1'b0, 3'd3, 12'd3, 12'd4, 20'd6, 24'h000040, 24'h000049, 4'd1, 8'hCD},
        '{1'b1, 3'd4, 12'd1, 12'd3, 20'd0, 24'h000080, 24'h000083, 4'd3, 8'h55},
        '{1'b0, 3'd0, 12'd0, 12'd0, 20'd3, 24'h0000FE, 24'h000102, 4'd0, 8'hFF},
        '{1'b0, 3'd5, 12'd4, 12'd4, 20'd7, 24'h0001F0, 24'h0001F8, 4'd2, 8'h3C}
    };

    logic        clk;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack;
    logic [7:0]  mem_rdata;
    logic [2:0]  per_sel;
    logic        per_tx_valid;
    logic [7:0]  per_tx_data;
    logic        per_tx_ready;
    logic        per_rx_valid;
    logic [7:0]  per_rx_data;
    logic        per_rx_ready;
    logic        irq;

    int tests = 0;
    int fails = 0;

    logic        clr;
    logic [3:0]  cur_lat;
    logic [7:0]  rdy_pat;
    logic [2:0]  cur_sel;
    int          budget;
    logic [2:0]  phase;
    logic [3:0]  lat_cnt;
    int          tx_cnt;
    int          rx_cnt;
    int          irq_cnt;
    logic        sel_bad;
    logic [7:0]  mem [0:511];
    logic [7:0]  tx_log [0:63];

    pdma_channel u_pdma_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .per_sel     (per_sel),
        .per_tx_valid(per_tx_valid),
        .per_tx_data (per_tx_data),
        .per_tx_ready(per_tx_ready),
        .per_rx_valid(per_rx_valid),
        .per_rx_data (per_rx_data),
        .per_rx_ready(per_rx_ready),
        .irq         (irq)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    function automatic logic [23:0] exp_addr(input logic [23:0] base, input logic [11:0] ch,
                                             input logic [11:0] st, input int k);
        if (ch == 12'd0) return base + 24'(k);
        return base + 24'((k / int'(ch)) * int'(st)) + 24'(k % int'(ch));
    endfunction

    assign per_tx_ready = rdy_pat[phase] && (tx_cnt < budget);
    assign per_rx_valid = rdy_pat[phase] && (rx_cnt < budget);
    assign per_rx_data  = 8'hC0 + rx_cnt[7:0];

    always @(posedge clk) begin
        phase <= phase + 3'd1;
        if (clr) begin
            mem_ack <= 1'b0;
            lat_cnt <= '0;
            tx_cnt  <= 0;
            rx_cnt  <= 0;
            irq_cnt <= 0;
            sel_bad <= 1'b0;
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
        end else begin
            if (irq) irq_cnt <= irq_cnt + 1;
            if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (lat_cnt >= cur_lat) begin
                    mem_ack <= 1'b1;
                    lat_cnt <= '0;
                    if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
                    else mem_rdata <= mem[mem_addr[8:0]];
                end else begin
                    lat_cnt <= lat_cnt + 4'd1;
                end
            end
            if (per_tx_valid && per_tx_ready) begin
                tx_log[tx_cnt[5:0]] <= per_tx_data;
                tx_cnt <= tx_cnt + 1;
                if (per_sel != cur_sel) sel_bad <= 1'b1;
            end
            if (per_rx_valid && per_rx_ready) begin
                rx_cnt <= rx_cnt + 1;
                if (per_sel != cur_sel) sel_bad <= 1'b1;
            end
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] d;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); #1;
            rd(RA_CMD, d);
            if (d[0] == 1'b0) break;
        end
    endtask

    task automatic reset_bench(input logic [3:0] lat, input logic [7:0] rp,
                               input logic [2:0] sel, input int bud);
        cur_lat = lat; rdy_pat = rp; cur_sel = sel; budget = bud;
        @(posedge clk); #1; clr = 1'b1;
        @(posedge clk); #1; clr = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        vec_t        v;
        int          nb;
        int          bad;
        logic        saw;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        clr = 1'b0; cur_lat = '0; rdy_pat = 8'hFF; cur_sel = '0; budget = 1000;
        phase = '0; mem_ack = 1'b0; mem_rdata = '0; lat_cnt = '0;
        tx_cnt = 0; rx_cnt = 0; irq_cnt = 0; sel_bad = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(RA_COUNT, d); check_eq("R1 count after reset", d, 32'h000FFFFF);
        rd(RA_ADDR, d);  check_eq("R1 address after reset", d, 32'h0);
        rd(RA_CMD, d);   check_eq("R1 busy after reset", d, 32'h0);
        check_eq("R1 irq after reset", {31'd0, irq}, 32'h0);
        check_eq("R1 port handshakes idle", {29'd0, mem_req, per_tx_valid, per_rx_ready}, 32'h0);

        // table of transfers
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            nb = int'(v.cnt) + 1;
            reset_bench(v.lat, v.rdy, v.sel, 1000);
            wr(RA_GLOBAL, 32'd1);
            wr(RA_XCTL, {28'd0, v.sel, v.dir});
            wr(RA_CHUNK, {20'd0, v.chunk});
            wr(RA_STRIDE, {20'd0, v.stride});
            wr(RA_COUNT, {12'd0, v.cnt});
            wr(RA_ADDR, {8'd0, v.addr});
            wr(RA_CMD, 32'd1);
            rd(RA_CMD, d); check_eq("R2 busy after go", d, 32'd1);
            wait_done();
            repeat (2) @(posedge clk);
            #1;
            check_eq("R9 one irq pulse", irq_cnt, 32'd1);
            rd(RA_COUNT, d); check_eq("R7 count after completion", d, 32'h000FFFFF);
            rd(RA_ADDR, d);  check_eq("R8 final address", d, {8'd0, v.fin});
            check_eq("R4 peripheral select during transfer", {31'd0, sel_bad}, 32'd0);
            bad = 0;
            if (v.dir) begin
                check_eq("R4 R11 bytes sent to peripheral", tx_cnt, nb);
                for (int k = 0; k < nb; k++)
                    if (tx_log[k] !== pat(int'(exp_addr(v.addr, v.chunk, v.stride, k) & 24'h1FF))) bad++;
            end else begin
                check_eq("R4 R11 bytes taken from peripheral", rx_cnt, nb);
                for (int k = 0; k < nb; k++)
                    if (mem[exp_addr(v.addr, v.chunk, v.stride, k) & 24'h1FF] !== 8'(8'hC0 + k)) bad++;
            end
            if (v.chunk == 12'd0) check_eq("R5 R12 contiguous walk mismatches", bad, 0);
            else check_eq("R6 R12 chunked walk mismatches", bad, 0);
        end

        // R10 global enable gates the transfer
        reset_bench(4'd1, 8'hFF, 3'd1, 1000);
        wr(RA_GLOBAL, 32'd0);
        wr(RA_XCTL, {28'd0, 3'd1, 1'b1});
        wr(RA_CHUNK, 32'd0);
        wr(RA_COUNT, 32'd2);
        wr(RA_ADDR, 32'h30);
        wr(RA_CMD, 32'd1);
        saw = 1'b0;
        repeat (20) begin
            @(posedge clk); #1;
            if (mem_req) saw = 1'b1;
        end
        check_eq("R10 no request while disabled", {31'd0, saw}, 32'd0);
        rd(RA_CMD, d);   check_eq("R10 still busy while disabled", d, 32'd1);
        rd(RA_COUNT, d); check_eq("R10 count unchanged while disabled", d, 32'd2);
        wr(RA_GLOBAL, 32'd1);
        wait_done();
        repeat (2) @(posedge clk);
        #1;
        check_eq("R10 bytes after enable", tx_cnt, 32'd3);
        check_eq("R10 irq after enable", irq_cnt, 32'd1);

        // R3 halt mid-transfer with a stalled peripheral
        reset_bench(4'd0, 8'hFF, 3'd2, 2);
        wr(RA_XCTL, {28'd0, 3'd2, 1'b1});
        wr(RA_COUNT, 32'd99);
        wr(RA_ADDR, 32'h100);
        wr(RA_CMD, 32'd1);
        repeat (40) @(posedge clk);
        #1;
        check_eq("R11 bytes before stall", tx_cnt, 32'd2);
        rd(RA_COUNT, d); check_eq("R7 live count mid-transfer", d, 32'd97);
        rd(RA_ADDR, d);  check_eq("R8 live address mid-transfer", d, 32'h102);
        check_eq("R11 stalled byte offered and held", {23'd0, per_tx_valid, per_tx_data},
                 {23'd0, 1'b1, pat(32'h102)});
        wr(RA_CMD, 32'd2);
        rd(RA_CMD, d); check_eq("R3 busy after halt", d, 32'd0);
        check_eq("R3 no valid after halt", {31'd0, per_tx_valid}, 32'd0);
        repeat (10) @(posedge clk);
        #1;
        check_eq("R3 no irq after halt", irq_cnt, 32'd0);
        rd(RA_COUNT, d); check_eq("R3 count kept after halt", d, 32'd97);
        check_eq("R3 no bytes after halt", tx_cnt, 32'd2);

        // R3 halt wins over go
        wr(RA_CMD, 32'd3);
        rd(RA_CMD, d); check_eq("R3 go with halt stays idle", d, 32'd0);
        repeat (5) @(posedge clk);
        #1;
        check_eq("R3 no request after go with halt", {31'd0, mem_req}, 32'd0);

        summary();
        $finish;
    end
endmodule